// File: doc/BRIEF.md
# Retired-Instruction Timer Compare Unit

This unit keeps a 64-bit event counter that moves forward by the number of instructions a core retires in each clock cycle. That number may be zero, one, or several. A programmable 32-bit compare value sits next to the counter. When the counter passes that value, a sticky timer-pending flag is raised. A match is found by looking at the low half of the counter minus the compare value. If the sign bit of that 32-bit difference changes across the increment, the counter has crossed the compare value. This means a crossing is seen even when a multi-instruction step jumps over the exact compare value.

Software reaches the unit through one CSR-style access port. Three aliases (cycle, time and retired-instruction) all name the same counter, and each has a matching high-half alias. The compare register has one more code. Writing the compare register loads it and clears the pending flag. A high-half read returns the counter shifted right by 32. When the core runs in 64-bit mode, the high-half aliases are illegal. The counter value, the compare value and the pending flag are also driven as plain outputs.

Top module: `instret_timer`

## Requirements
- R1: After reset the counter, the compare value and the pending flag are all zero.
- R2: Each clock edge without a counter write adds `retire_cnt` (0 to 15) to the 64-bit counter, and counting goes on while pending is set.
- R3: Pending becomes 1 at the edge where bit 31 of (counter[31:0] - compare), taken modulo 2^32, differs before and after adding `retire_cnt`. This includes a step that jumps past the compare value. A step that starts at or above the compare value and stays below compare + 2^31 leaves pending at 0.
- R4: Once set, pending stays 1 until the next compare write.
- R5: A write to code 6 loads `csr_wdata[31:0]` into the compare register and clears pending at the same edge.
- R6: A write to codes 0, 1 or 2 replaces the whole counter with `csr_wdata`. If `retire_cnt` is nonzero in that cycle, the increment is dropped.
- R7: A write to codes 3, 4 or 5 puts `csr_wdata[31:0]` in counter[63:32] and keeps counter[31:0]. The increment of that cycle is dropped.
- R8: Reads of codes 0, 1 and 2 all return the full counter. Code 6 returns the compare value zero-extended. Code 7 sets `csr_illegal` and returns 0.
- R9: With `wide_mode`=0, reads of codes 3, 4 and 5 return the counter shifted right by 32. With `wide_mode`=1, those codes set `csr_illegal` and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 when the core runs in 64-bit mode |
| retire_cnt | input | 4 | Instructions retired this cycle |
| csr_addr | input | 3 | Register code for read and write |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for `csr_addr` (combinational) |
| csr_illegal | output | 1 | Read code is illegal in the current mode |
| count_o | output | 64 | Counter value |
| compare_o | output | 32 | Compare value |
| pending_o | output | 1 | Sticky timer-pending flag |

## Verification
The assertions check these rules on every cycle:
- the counter adds the retire count at each edge with no write;
- a high-half write keeps the low half;
- a compare write clears pending and loads the new value;
- pending never drops on its own;
- high-half reads are illegal in 64-bit mode.

Some behaviour can only be shown by the bench's scenarios, because it depends on chosen numeric values:
- an exact hit of the compare value;
- a multi-instruction jump past it;
- a step that starts at the compare value and so raises nothing;
- a counter write that collides with an increment.

// File: rtl/instret_timer.sv
module instret_timer #(
  parameter int CNT_W  = 64,
  parameter int INC_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic [INC_W-1:0]  retire_cnt,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_we,
  input  logic [CNT_W-1:0]  csr_wdata,
  output logic [CNT_W-1:0]  csr_rdata,
  output logic              csr_illegal,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W/2-1:0] compare_o,
  output logic              pending_o
);
  localparam int HALF = CNT_W / 2;
  localparam logic [ADDR_W-1:0] C_CYC   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] C_TIM   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] C_RET   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] C_CYCH  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] C_TIMH  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] C_RETH  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] C_CMP   = ADDR_W'(6);

  logic [CNT_W-1:0] count;
  logic [HALF-1:0]  compare;
  logic             pending;

  logic is_lo, is_hi, wr_lo, wr_hi, wr_cmp;
  logic [HALF-1:0] gap_before, gap_after;
  logic crossed;

  assign is_lo  = (csr_addr == C_CYC)  || (csr_addr == C_TIM)  || (csr_addr == C_RET);
  assign is_hi  = (csr_addr == C_CYCH) || (csr_addr == C_TIMH) || (csr_addr == C_RETH);
  assign wr_lo  = csr_we && is_lo;
  assign wr_hi  = csr_we && is_hi;
  assign wr_cmp = csr_we && (csr_addr == C_CMP);

  assign gap_before = count[HALF-1:0] - compare;
  assign gap_after  = gap_before + HALF'(retire_cnt);
  assign crossed    = gap_before[HALF-1] ^ gap_after[HALF-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_lo) begin
      count <= csr_wdata;
    end else if (wr_hi) begin
      count <= {csr_wdata[HALF-1:0], count[HALF-1:0]};
    end else begin
      count <= count + CNT_W'(retire_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      compare <= '0;
    end else if (wr_cmp) begin
      compare <= csr_wdata[HALF-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (wr_cmp) begin
      pending <= 1'b0;
    end else if (!wr_lo && !wr_hi && crossed) begin
      pending <= 1'b1;
    end
  end

  always_comb begin
    csr_rdata   = '0;
    csr_illegal = 1'b0;
    if (is_lo) begin
      csr_rdata = count;
    end else if (is_hi) begin
      if (wide_mode) csr_illegal = 1'b1;
      else           csr_rdata   = count >> HALF;
    end else if (csr_addr == C_CMP) begin
      csr_rdata = CNT_W'(compare);
    end else begin
      csr_illegal = 1'b1;
    end
  end

  assign count_o   = count;
  assign compare_o = compare;
  assign pending_o = pending;
endmodule

// File: rtl/instret_timer_chk.sv
module instret_timer_chk #(
  parameter int CNT_W  = 64,
  parameter int INC_W  = 4,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wide_mode,
  input logic [INC_W-1:0]  retire_cnt,
  input logic [ADDR_W-1:0] csr_addr,
  input logic              csr_we,
  input logic [CNT_W-1:0]  csr_wdata,
  input logic [CNT_W-1:0]  csr_rdata,
  input logic              csr_illegal,
  input logic [CNT_W-1:0]  count_o,
  input logic [CNT_W/2-1:0] compare_o,
  input logic              pending_o
);
  localparam int HALF = CNT_W / 2;
  logic started;
  logic any_cnt_wr, hi_wr, cmp_wr, hi_code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;

  assign hi_code    = (csr_addr == ADDR_W'(3)) || (csr_addr == ADDR_W'(4)) || (csr_addr == ADDR_W'(5));
  assign hi_wr      = csr_we && hi_code;
  assign cmp_wr     = csr_we && (csr_addr == ADDR_W'(6));
  assign any_cnt_wr = csr_we && (csr_addr <= ADDR_W'(5));

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    started && !any_cnt_wr |=> count_o == $past(count_o) + CNT_W'($past(retire_cnt))); // R2

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    started && pending_o && !cmp_wr |=> pending_o); // R4

  AST_CMP_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    started && cmp_wr |=> !pending_o && compare_o == $past(csr_wdata[HALF-1:0])); // R5

  AST_HI_WR_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    started && hi_wr |=> count_o[HALF-1:0] == $past(count_o[HALF-1:0])
                      && count_o[CNT_W-1:HALF] == $past(csr_wdata[HALF-1:0])); // R7

  AST_HI_RD_ILLEGAL_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode && hi_code |-> csr_illegal && csr_rdata == '0); // R9
endmodule

bind instret_timer instret_timer_chk #(.CNT_W(CNT_W), .INC_W(INC_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_instret_timer.sv
`timescale 1ns/1ps
module tb_instret_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic [3:0]  retire_cnt = '0;
  logic [2:0]  csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        csr_illegal;
  logic [63:0] count_o;
  logic [31:0] compare_o;
  logic        pending_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  instret_timer dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic step(input logic [3:0] n, input int cycles);
    retire_cnt = n;
    repeat (cycles) @(negedge clk);
    retire_cnt = '0;
  endtask

  task automatic t_reset();
    chk("R1 count", count_o, 64'd0);
    chk("R1 compare", {32'd0, compare_o}, 64'd0);
    chk("R1 pending", {63'd0, pending_o}, 64'd0);
  endtask

  task automatic t_count();
    step(4'd3, 4);
    chk("R2 multi-step", count_o, 64'd12);
    step(4'd1, 1);
    chk("R2 single", count_o, 64'd13);
    csr_addr = 3'd0; #1 chk("R8 cycle alias", csr_rdata, 64'd13);
    csr_addr = 3'd1; #1 chk("R8 time alias", csr_rdata, 64'd13);
    csr_addr = 3'd2; #1 chk("R8 instret alias", csr_rdata, 64'd13);
  endtask

  task automatic t_exact_hit();
    wr(3'd6, 64'd100);
    csr_addr = 3'd6; #1 chk("R8 compare read", csr_rdata, 64'd100);
    wr(3'd0, 64'd99);
    chk("R3 not yet", {63'd0, pending_o}, 64'd0);
    step(4'd1, 1);
    chk("R3 exact hit count", count_o, 64'd100);
    chk("R3 exact hit pending", {63'd0, pending_o}, 64'd1);
    step(4'd2, 3);
    chk("R4 still pending", {63'd0, pending_o}, 64'd1);
    chk("R4 counting goes on", count_o, 64'd106);
    wr(3'd6, 64'd200);
    chk("R5 pending cleared", {63'd0, pending_o}, 64'd0);
    chk("R5 compare loaded", {32'd0, compare_o}, 64'd200);
  endtask

  task automatic t_jump();
    wr(3'd1, 64'd195);
    step(4'd7, 1);
    chk("R3 jump count", count_o, 64'd202);
    chk("R3 jump past", {63'd0, pending_o}, 64'd1);
    wr(3'd6, 64'd500);
    wr(3'd2, 64'd500);
    step(4'd4, 1);
    chk("R3 start at compare", {63'd0, pending_o}, 64'd0);
    chk("R3 start at compare count", count_o, 64'd504);
  endtask

  task automatic t_collide();
    retire_cnt = 4'd5;
    wr(3'd0, 64'h0000_0001_0000_03E8);
    retire_cnt = '0;
    chk("R6 write wins over increment", count_o, 64'h0000_0001_0000_03E8);
  endtask

  task automatic t_high();
    retire_cnt = 4'd9;
    wr(3'd4, 64'hFFFF_FFFF_0000_ABCD);
    retire_cnt = '0;
    chk("R7 high write", count_o, 64'h0000_ABCD_0000_03E8);
    wide_mode = 1'b0;
    csr_addr = 3'd5; #1 chk("R9 high read narrow", csr_rdata, 64'h0000_0000_0000_ABCD);
    chk("R9 high legal narrow", {63'd0, csr_illegal}, 64'd0);
    wide_mode = 1'b1;
    csr_addr = 3'd3; #1 chk("R9 high illegal wide", {63'd0, csr_illegal}, 64'd1);
    chk("R9 high wide data", csr_rdata, 64'd0);
    csr_addr = 3'd7; #1 chk("R8 code 7 illegal", {63'd0, csr_illegal}, 64'd1);
    wide_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_exact_hit();
    t_jump();
    t_collide();
    t_high();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule